// File: doc/BRIEF.md
# Seven-Channel Priority Interrupt Arbiter

This block decides which interrupt channel a processor should serve next. It has seven channels with fixed priorities. It keeps four pieces of state:

- an enable mask, one bit per channel;
- a pending-request register;
- an in-service (held) register;
- a global active flag.

From these it produces a one-hot grant for the single channel that should be taken next. A channel is granted only when it ranks above every channel already in service, so lower-priority work never interrupts higher-priority work.

The surrounding processor logic decides when to act on the grant. It does so with single-cycle pulses:

- a strobe samples the device request lines through the enable mask;
- a hold pulse moves the granted channel into service;
- a dismiss pulse ends the highest-priority service in progress;
- direct loads replace the request or held register;
- a configuration write sets the enable mask and the active flag.

All state changes on the rising clock edge. The grant follows the registers combinationally.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Channels are one-hot bits of a 7-bit vector. Bit 6 has the highest priority and bit 0 the lowest. `grant` is always zero or one-hot.
- R2: `grant` is the highest-priority pending bit when no in-service bit sits at or above it. Otherwise `grant` is zero. It follows register changes within the same cycle.
- R3: While the active flag is clear, `grant` is zero whatever the register contents.
- R4: A cycle with `req_stb` high ORs (`dev_req` AND enable mask) into the request register. The mask used is the value held before that edge.
- R5: A bit that is in service after an edge is never set in the request register after that edge, whatever the strobe or direct load.
- R6: `held_ld` replaces the held register with `held_ld_val` and clears the matching request bits.
- R7: `hold_p` ORs the granted bit into the held register and removes it from the request register. When `grant` is zero it changes nothing.
- R8: `dismiss_p` clears only the highest-priority held bit, and only while the active flag is set. While the flag is clear the held register is unchanged.
- R9: When `dismiss_p` and `hold_p` are high together, the dismiss is applied first. The hold then uses the grant recomputed from the reduced held register.
- R10: Synchronous `rst` clears the request, held and mask registers and the active flag, so `grant` is zero.
- R11: `cfg_we` loads `cfg_mask` and `cfg_active`. They take effect from the next cycle.
- R12: `req_ld` replaces the request register with `req_ld_val`, minus the held bits. A strobe in the same cycle is ORed on top of the loaded value.
- R13: `held_ld` takes precedence over `hold_p` and `dismiss_p` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load enable mask and active flag |
| cfg_active | input | 1 | New active flag value |
| cfg_mask | input | 7 | New per-channel enable mask |
| dev_req | input | 7 | Device request lines |
| req_stb | input | 1 | Sample device requests through the mask |
| req_ld | input | 1 | Direct load of the request register |
| req_ld_val | input | 7 | Value for the request load |
| held_ld | input | 1 | Direct load of the held register |
| held_ld_val | input | 7 | Value for the held load |
| hold_p | input | 1 | Move the granted channel into service |
| dismiss_p | input | 1 | End the highest-priority service |
| grant | output | 7 | One-hot channel to serve next, or zero |
| req_q | output | 7 | Request register |
| held_q | output | 7 | Held register |
| active_q | output | 1 | Active flag |

## Verification
The embedded properties check, on every cycle:

- the one-hot shape of the grant;
- that the request and held registers never overlap;
- that the grant is silent while inactive and always ranks above every held channel;
- the reset values;
- that a lone dismiss removes exactly one held bit;
- the strobe merge;
- that a hold lands the granted bit in service.

Three things need the bench's directed sequences and its per-cycle reference model:

- that the dismiss removes the *highest* held bit;
- the ordering when dismiss and hold coincide;
- the precedence of a held load over the pulses.

The model also shows that a masked or in-service channel stays out of the request register after a strobe or load.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic {
      PRIO_MSB_FIRST = 1'b0,
      PRIO_LSB_FIRST = 1'b1
   } prio_order_e;

   localparam int unsigned PIC_DEFAULT_CH = 7;
endpackage

// File: rtl/pic_first_one.sv
// One-hot isolation of the highest-priority set bit, direction chosen by ORDER.
module pic_first_one #(
   parameter int unsigned          W     = pic_pkg::PIC_DEFAULT_CH,
   parameter pic_pkg::prio_order_e ORDER = pic_pkg::PRIO_MSB_FIRST
) (
   input  logic [W-1:0] vec,
   output logic [W-1:0] first
);
   if (W < 1) begin : g_bad_width
      $error("pic_first_one: W must be at least 1");
   end

   if (ORDER == pic_pkg::PRIO_MSB_FIRST) begin : g_msb
      // seen[i] : some bit at position >= i is set
      logic [W:0] seen;
      assign seen[W] = 1'b0;
      for (genvar i = W - 1; i >= 0; i--) begin : g_bit
         assign seen[i]  = seen[i+1] | vec[i];
         assign first[i] = vec[i] & ~seen[i+1];
      end
   end else begin : g_lsb
      // seen[i] : some bit at position < i is set
      logic [W:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign seen[i+1] = seen[i] | vec[i];
         assign first[i]  = vec[i] & ~seen[i];
      end
   end
endmodule

// File: rtl/pic_arbiter.sv
// Grant = leading bit of (pending | in-service), kept only if it is pending.
module pic_arbiter #(
   parameter int unsigned          W     = pic_pkg::PIC_DEFAULT_CH,
   parameter pic_pkg::prio_order_e ORDER = pic_pkg::PRIO_MSB_FIRST
) (
   input  logic         active,
   input  logic [W-1:0] pend,
   input  logic [W-1:0] busy,
   output logic [W-1:0] grant
);
   logic [W-1:0] lead;

   pic_first_one #(.W(W), .ORDER(ORDER)) u_lead (
      .vec   (pend | busy),
      .first (lead)
   );

   always_comb begin
      grant = '0;
      if (active) grant = lead & pend;
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int unsigned          NCH   = pic_pkg::PIC_DEFAULT_CH,
   parameter pic_pkg::prio_order_e ORDER = pic_pkg::PRIO_MSB_FIRST
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cfg_we,
   input  logic           cfg_active,
   input  logic [NCH-1:0] cfg_mask,
   input  logic [NCH-1:0] dev_req,
   input  logic           req_stb,
   input  logic           req_ld,
   input  logic [NCH-1:0] req_ld_val,
   input  logic           held_ld,
   input  logic [NCH-1:0] held_ld_val,
   input  logic           hold_p,
   input  logic           dismiss_p,
   output logic [NCH-1:0] grant,
   output logic [NCH-1:0] req_q,
   output logic [NCH-1:0] held_q,
   output logic           active_q
);
   localparam int unsigned MAX_CH = 64;

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("irq_prio_ctrl: NCH out of range");
   end

   logic [NCH-1:0] mask_q;
   logic [NCH-1:0] top_held;      // highest-priority in-service bit
   logic [NCH-1:0] held_after_dis;
   logic [NCH-1:0] grant_after_dis;
   logic [NCH-1:0] held_n;
   logic [NCH-1:0] req_base;
   logic [NCH-1:0] req_n;

   // Grant seen by the processor, from the current registers (R2, R3)
   pic_arbiter #(.W(NCH), .ORDER(ORDER)) u_grant_now (
      .active (active_q),
      .pend   (req_q),
      .busy   (held_q),
      .grant  (grant)
   );

   // Dismiss target (R8)
   pic_first_one #(.W(NCH), .ORDER(ORDER)) u_top_held (
      .vec   (held_q),
      .first (top_held)
   );

   assign held_after_dis = (dismiss_p && active_q) ? (held_q & ~top_held) : held_q;

   // Grant after the dismiss, used by a coinciding hold (R9)
   pic_arbiter #(.W(NCH), .ORDER(ORDER)) u_grant_dis (
      .active (active_q),
      .pend   (req_q),
      .busy   (held_after_dis),
      .grant  (grant_after_dis)
   );

   always_comb begin
      held_n = held_after_dis;
      if (hold_p)  held_n = held_n | grant_after_dis;   // R7
      if (held_ld) held_n = held_ld_val;                // R6, R13
      req_base = req_ld ? req_ld_val : req_q;           // R12
      if (req_stb) req_base = req_base | (mask_q & dev_req);  // R4
      req_n = req_base & ~held_n;                       // R5
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q    <= '0;
         held_q   <= '0;
         mask_q   <= '0;
         active_q <= 1'b0;
      end else begin
         req_q  <= req_n;
         held_q <= held_n;
         if (cfg_we) begin
            mask_q   <= cfg_mask;
            active_q <= cfg_active;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r1_grant_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
      (req_q & held_q) == '0);

   a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
      !active_q |-> grant == '0);

   if (ORDER == pic_pkg::PRIO_MSB_FIRST) begin : g_rank_msb
      a_r2_outranks_held: assert property (@(posedge clk) disable iff (rst)
         grant != '0 |-> grant > held_q);
   end else begin : g_rank_lsb
      a_r2_outranks_held: assert property (@(posedge clk) disable iff (rst)
         grant != '0 |-> (held_q & (grant - 1'b1)) == '0);
   end

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (req_q == '0 && held_q == '0 && !active_q && grant == '0));

   a_r8_dismiss_one: assert property (@(posedge clk) disable iff (rst)
      (dismiss_p && active_q && !hold_p && !held_ld && held_q != '0)
      |=> $countones(held_q) + 1 == $countones($past(held_q)));

   a_r4_strobe_merge: assert property (@(posedge clk) disable iff (rst)
      (req_stb && !req_ld && !held_ld && !hold_p)
      |=> req_q == (($past(req_q) | ($past(mask_q) & $past(dev_req))) & ~held_q));

   a_r7_hold_moves: assert property (@(posedge clk) disable iff (rst)
      (hold_p && !held_ld && !dismiss_p && grant != '0)
      |=> (held_q & $past(grant)) != '0 && (req_q & $past(grant)) == '0);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_we = 1'b0, cfg_active = 1'b0;
   logic [6:0] cfg_mask = '0, dev_req = '0, req_ld_val = '0, held_ld_val = '0;
   logic req_stb = 1'b0, req_ld = 1'b0, held_ld = 1'b0, hold_p = 1'b0, dismiss_p = 1'b0;
   logic [6:0] grant, req_q, held_q;
   logic active_q;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // reference state
   bit [6:0] m_req = '0, m_held = '0, m_mask = '0;
   bit       m_act = 1'b0;

   always #5 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_active(cfg_active),
      .cfg_mask(cfg_mask), .dev_req(dev_req), .req_stb(req_stb),
      .req_ld(req_ld), .req_ld_val(req_ld_val), .held_ld(held_ld),
      .held_ld_val(held_ld_val), .hold_p(hold_p), .dismiss_p(dismiss_p),
      .grant(grant), .req_q(req_q), .held_q(held_q), .active_q(active_q)
   );

   function automatic bit [6:0] m_grant(bit [6:0] r, bit [6:0] h, bit a);
      if (!a) return '0;
      for (int ch = 6; ch >= 0; ch--) begin
         if (h[ch]) return '0;
         if (r[ch]) return 7'(1 << ch);
      end
      return '0;
   endfunction

   task automatic chk(string tag, string what, logic [6:0] act, logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit [6:0] h, r, g;
      if (rst) begin
         m_req = '0; m_held = '0; m_mask = '0; m_act = 1'b0;
         return;
      end
      h = m_held;
      if (dismiss_p && m_act) begin
         for (int ch = 6; ch >= 0; ch--) begin
            if (h[ch]) begin
               h[ch] = 1'b0;
               break;
            end
         end
      end
      g = m_grant(m_req, h, m_act);
      if (hold_p) h = h | g;
      if (held_ld) h = held_ld_val;
      r = req_ld ? req_ld_val : m_req;
      if (req_stb) r = r | (m_mask & dev_req);
      r = r & ~h;
      if (cfg_we) begin
         m_mask = cfg_mask;
         m_act  = cfg_active;
      end
      m_req  = r;
      m_held = h;
   endtask

   task automatic idle();
      rst = 1'b0; cfg_we = 1'b0; req_stb = 1'b0; req_ld = 1'b0;
      held_ld = 1'b0; hold_p = 1'b0; dismiss_p = 1'b0;
   endtask

   // inputs already driven, at a negative edge
   task automatic tick(string tag);
      #1;
      chk(tag, "grant(pre)", grant, m_grant(m_req, m_held, m_act));
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, "req", req_q, m_req);
      chk(tag, "held", held_q, m_held);
      chk(tag, "active", {6'd0, active_q}, {6'd0, m_act});
      chk(tag, "grant", grant, m_grant(m_req, m_held, m_act));
      idle();
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog R10 actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      rst = 1'b1;
      tick("R10");
      chk("R10", "reset req", req_q, 7'b0);
      chk("R10", "reset grant", grant, 7'b0);

      cfg_we = 1'b1; cfg_mask = 7'h7F; cfg_active = 1'b1;
      tick("R11");
      req_stb = 1'b1; dev_req = 7'b0010100;
      tick("R4");
      chk("R2", "highest pending", grant, 7'b0010000);

      cfg_we = 1'b1; cfg_mask = 7'b0000011; cfg_active = 1'b1;
      tick("R11");
      req_stb = 1'b1; dev_req = 7'b1000001;
      tick("R4");
      chk("R4", "masked strobe", req_q, 7'b0010101);

      hold_p = 1'b1;
      tick("R7");
      chk("R7", "held after hold", held_q, 7'b0010000);
      chk("R2", "blocked by held", grant, 7'b0000000);

      cfg_we = 1'b1; cfg_mask = 7'h7F; cfg_active = 1'b1;
      tick("R11");
      req_stb = 1'b1; dev_req = 7'b1000000;
      tick("R2");
      chk("R2", "above held", grant, 7'b1000000);
      hold_p = 1'b1;
      tick("R7");
      req_stb = 1'b1; dev_req = 7'b1010000;
      tick("R5");
      chk("R5", "held not retriggered", req_q, 7'b0000101);

      req_ld = 1'b1; req_ld_val = 7'h7F;
      tick("R12");
      chk("R12", "direct load minus held", req_q, 7'b0101111);

      cfg_we = 1'b1; cfg_mask = 7'h7F; cfg_active = 1'b0;
      tick("R3");
      chk("R3", "inactive grant", grant, 7'b0);
      dismiss_p = 1'b1;
      tick("R8");
      chk("R8", "dismiss while inactive", held_q, 7'b1010000);
      hold_p = 1'b1;
      tick("R3");

      cfg_we = 1'b1; cfg_mask = 7'h7F; cfg_active = 1'b1;
      tick("R11");
      dismiss_p = 1'b1;
      tick("R8");
      chk("R8", "top held cleared", held_q, 7'b0010000);
      chk("R2", "grant after dismiss", grant, 7'b0100000);

      dismiss_p = 1'b1; hold_p = 1'b1;
      tick("R9");
      chk("R9", "held", held_q, 7'b0100000);
      chk("R9", "req", req_q, 7'b0001111);

      held_ld = 1'b1; held_ld_val = 7'b0000011;
      tick("R6");
      chk("R6", "req cleared", req_q, 7'b0001100);
      chk("R6", "grant", grant, 7'b0001000);

      held_ld = 1'b1; held_ld_val = 7'b0000100; hold_p = 1'b1; dismiss_p = 1'b1;
      tick("R13");
      chk("R13", "load wins", held_q, 7'b0000100);

      req_ld = 1'b1; req_ld_val = 7'b0000001; req_stb = 1'b1; dev_req = 7'b0100000;
      tick("R12");
      chk("R12", "load plus strobe", req_q, 7'b0100001);

      for (int n = 0; n < 600; n++) begin
         rst         = ($urandom_range(0, 99) == 0);
         cfg_we      = ($urandom_range(0, 9) == 0);
         cfg_active  = ($urandom_range(0, 4) != 0);
         cfg_mask    = 7'($urandom);
         dev_req     = 7'($urandom);
         req_stb     = ($urandom_range(0, 2) == 0);
         req_ld      = ($urandom_range(0, 11) == 0);
         req_ld_val  = 7'($urandom);
         held_ld     = ($urandom_range(0, 15) == 0);
         held_ld_val = 7'($urandom);
         hold_p      = ($urandom_range(0, 2) == 0);
         dismiss_p   = ($urandom_range(0, 3) == 0);
         tick("R1");
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule